// File: doc/BRIEF.md
# Memory-Mapped SPI Master Controller

This block is a register-driven SPI master. Software picks one of up to eight peripheral select lines and drives it through a control register. It sets clock polarity, clock phase, the bit order for each direction and the word length (8 or 16 bits) through a configuration register. It then writes a word to the data-out register. That write launches one full-duplex word exchange. The word shifted in from MISO lands in the data-in register, and a cause register goes nonzero when the exchange is over.

The SCK rate comes from outside: a separate divider supplies `sck_tick`, and every tick that arrives during an exchange moves SCK by one edge. A small sample-strobe pipeline lets software move the MISO capture point a few core cycles after the sampling edge, so that slow peripherals can be read.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset every line of `spi_cs_n` is high, the control, configuration, cause and data-in registers read 0, and the timing register reads 0x40 (sample-point field = 1).
- R2: `spi_cs_n[k]` is low exactly when control bit 0 is 1 and control bits 4:2 equal k; all other lines stay high.
- R3: While idle, SCK rests at the level in configuration bit 11 (polarity). An exchange of N bits makes exactly 2N SCK edges and ends with SCK back at that level. With configuration bit 12 (phase) clear, MOSI carries the first bit before the first edge and both sides sample on odd-numbered edges. With bit 12 set, they sample on even-numbered edges.
- R4: Configuration bit 13 set sends data-out bit 0 first; clear sends bit N-1 first.
- R5: Configuration bit 14 set places the first received bit in data-in bit 0; clear places it in bit N-1.
- R6: Configuration bit 5 set selects N = 16, clear selects N = 8. Data-in (offset 0x0C) holds the received word zero-extended to 32 bits, updated when an exchange completes.
- R7: SCK changes only in a cycle where `sck_tick` is high during an exchange. The sample-delay behaviour assumes ticks at least 4 cycles apart.
- R8: Completion sets the cause register (offset 0x10) to 1. A write to it with bit 0 clear clears it; a write with bit 0 set leaves it unchanged.
- R9: Timing-register bits 7:6 (offset 0x18) hold a delay d, where 0 acts as 1. MISO is captured at the d-th clock edge after the edge that produced the sampling SCK edge.
- R10: A write to data-out (offset 0x08) during an exchange is ignored: the ongoing exchange, the data-out readback and the cause register are unaffected, and no new exchange starts.
- R11: Control (0x00), configuration (0x04), timing (0x18) and data-out (low 16 bits) read back their stored fields with other bits 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sck_tick | input | 1 | Half-period enable from the baud divider |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low peripheral selects |

## Verification
A wrong edge counter or a phase flag latched wrong shows up within one exchange. The edge count and final SCK level are wrong, or MOSI bits land on the wrong edges, and a scoreboard sees this as soon as the Nth sampled bit arrives. A misplaced capture strobe shows up only in the data-in word at completion. It is therefore stressed with a peripheral model that delays its MISO updates, so that delay 1 and delay 2 give different received words. A stale busy flag shows up as a second exchange or a changed data-out readback after an ignored write.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
   localparam int unsigned OFF_CTRL   = 32'h00;
   localparam int unsigned OFF_CONF   = 32'h04;
   localparam int unsigned OFF_DOUT   = 32'h08;
   localparam int unsigned OFF_DIN    = 32'h0C;
   localparam int unsigned OFF_CAUSE  = 32'h10;
   localparam int unsigned OFF_TIMING = 32'h18;

   localparam int WORD_BITS = 16;

   // configuration bit positions
   localparam int CONF_WIDE  = 5;
   localparam int CONF_CPOL  = 11;
   localparam int CONF_CPHA  = 12;
   localparam int CONF_TXLSB = 13;
   localparam int CONF_RXLSB = 14;
   localparam int TIM_SMP    = 6;

   typedef struct packed {
      logic       wide;
      logic       cpol;
      logic       cpha;
      logic       tx_lsb;
      logic       rx_lsb;
      logic [1:0] smp;
   } xfer_cfg_t;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_RUN   = 2'd1,
      SH_DRAIN = 2'd2
   } shift_state_e;

   // mirror the low 16 or low 8 bits of a word
   function automatic logic [WORD_BITS-1:0] flip_n(input logic [WORD_BITS-1:0] v,
                                                   input logic wide);
      logic [WORD_BITS-1:0] r;
      r = '0;
      if (wide) begin
         for (int i = 0; i < WORD_BITS; i++) r[WORD_BITS-1-i] = v[i];
      end else begin
         for (int i = 0; i < WORD_BITS/2; i++) r[WORD_BITS/2-1-i] = v[i];
      end
      return r;
   endfunction
endpackage

// File: rtl/spi_host_csdec.sv
`timescale 1ns/1ps
module spi_host_csdec #(
   parameter int NUM_CS = 8,
   parameter int IDX_W  = 3
) (
   input  logic              en_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [NUM_CS-1:0] cs_n_o
);
   if (NUM_CS < 2 || NUM_CS > 8) begin : g_bad_cs
      $error("spi_host_csdec: NUM_CS must be 2..8");
   end
   if ((1 << IDX_W) < NUM_CS) begin : g_bad_idx
      $error("spi_host_csdec: IDX_W too narrow");
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_line
      assign cs_n_o[g] = !(en_i && (idx_i == IDX_W'(g)));
   end
endmodule

// File: rtl/spi_host_regs.sv
`timescale 1ns/1ps
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   input  logic                 busy_i,
   input  logic                 done_i,
   input  logic [WORD_BITS-1:0] rx_i,
   output xfer_cfg_t            cfg_o,
   output logic                 start_o,
   output logic [WORD_BITS-1:0] tx_o,
   output logic                 cs_en_o,
   output logic [IDX_W-1:0]     cs_idx_o
);
   if (DATA_W < 16) begin : g_bad_data
      $error("spi_host_regs: DATA_W must be at least 16");
   end
   if (IDX_W > 3 || IDX_W < 1) begin : g_bad_idx
      $error("spi_host_regs: select index field is 1..3 bits");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("spi_host_regs: ADDR_W too small for the register map");
   end

   logic hit_ctrl, hit_conf, hit_dout, hit_din, hit_cause, hit_tim;
   assign hit_ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
   assign hit_conf  = (addr_i == ADDR_W'(OFF_CONF));
   assign hit_dout  = (addr_i == ADDR_W'(OFF_DOUT));
   assign hit_din   = (addr_i == ADDR_W'(OFF_DIN));
   assign hit_cause = (addr_i == ADDR_W'(OFF_CAUSE));
   assign hit_tim   = (addr_i == ADDR_W'(OFF_TIMING));

   logic                 en_q;
   logic [IDX_W-1:0]     idx_q;
   xfer_cfg_t            cfg_q;
   logic [WORD_BITS-1:0] dout_q;
   logic [WORD_BITS-1:0] din_q;
   logic                 cause_q;

   logic unused_wbits;
   assign unused_wbits = ^wdata_i;

   assign start_o = we_i && hit_dout && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         idx_q   <= '0;
         cfg_q   <= '{wide: 1'b0, cpol: 1'b0, cpha: 1'b0, tx_lsb: 1'b0,
                      rx_lsb: 1'b0, smp: 2'd1};
         dout_q  <= '0;
         din_q   <= '0;
         cause_q <= 1'b0;
      end else begin
         if (we_i && hit_ctrl) begin
            en_q  <= wdata_i[0];
            idx_q <= wdata_i[2 +: IDX_W];
         end
         if (we_i && hit_conf) begin
            cfg_q.wide   <= wdata_i[CONF_WIDE];
            cfg_q.cpol   <= wdata_i[CONF_CPOL];
            cfg_q.cpha   <= wdata_i[CONF_CPHA];
            cfg_q.tx_lsb <= wdata_i[CONF_TXLSB];
            cfg_q.rx_lsb <= wdata_i[CONF_RXLSB];
         end
         if (we_i && hit_tim) begin
            cfg_q.smp <= wdata_i[TIM_SMP +: 2];
         end
         if (start_o) begin
            dout_q <= wdata_i[WORD_BITS-1:0];
         end
         if (done_i) begin
            din_q   <= rx_i;
            cause_q <= 1'b1;
         end else if (we_i && hit_cause && !wdata_i[0]) begin
            cause_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_ctrl) begin
         rdata_o[0]          = en_q;
         rdata_o[2 +: IDX_W] = idx_q;
      end else if (hit_conf) begin
         rdata_o[CONF_WIDE]  = cfg_q.wide;
         rdata_o[CONF_CPOL]  = cfg_q.cpol;
         rdata_o[CONF_CPHA]  = cfg_q.cpha;
         rdata_o[CONF_TXLSB] = cfg_q.tx_lsb;
         rdata_o[CONF_RXLSB] = cfg_q.rx_lsb;
      end else if (hit_dout) begin
         rdata_o[WORD_BITS-1:0] = dout_q;
      end else if (hit_din) begin
         rdata_o[WORD_BITS-1:0] = din_q;
      end else if (hit_cause) begin
         rdata_o[0] = cause_q;
      end else if (hit_tim) begin
         rdata_o[TIM_SMP +: 2] = cfg_q.smp;
      end
   end

   assign cfg_o    = cfg_q;
   assign tx_o     = dout_q;
   assign cs_en_o  = en_q;
   assign cs_idx_o = idx_q;

   AST_BUSY_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && we_i && hit_dout) |=> $stable(dout_q)); // R10
   AST_CAUSE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> cause_q); // R8
   AST_DIN_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (din_q == $past(rx_i))); // R6
endmodule

// File: rtl/spi_host_shift.sv
`timescale 1ns/1ps
module spi_host_shift
   import spi_host_pkg::*;
#(
   parameter int SMP_TAPS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  xfer_cfg_t            cfg_i,
   input  logic [WORD_BITS-1:0] tx_i,
   input  logic                 tick_i,
   input  logic                 miso_i,
   output logic                 sck_o,
   output logic                 mosi_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [WORD_BITS-1:0] rx_o
);
   localparam int CNT_W = $clog2(2*WORD_BITS);

   if (SMP_TAPS < 3) begin : g_bad_taps
      $error("spi_host_shift: SMP_TAPS must cover the 2-bit delay field");
   end

   shift_state_e         st_q;
   xfer_cfg_t            cfg_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [WORD_BITS-1:0] txsr_q;
   logic [WORD_BITS-1:0] rxsr_q;
   logic [WORD_BITS-1:0] rx_q;
   logic                 sck_q;
   logic [SMP_TAPS-1:0]  pipe_q;
   logic [1:0]           dcnt_q;
   logic                 done_q;

   logic                 running, lead, samp_edge, shift_edge, capture;
   logic [CNT_W-1:0]     last_cnt;
   logic [1:0]           dly;
   logic [WORD_BITS-1:0] rx_next, rx_raw, rx_res;
   logic [WORD_BITS-1:0] tx_ord, tx_load;

   assign running  = (st_q == SH_RUN);
   assign last_cnt = cfg_q.wide ? CNT_W'(2*WORD_BITS-1) : CNT_W'(WORD_BITS-1);
   assign lead     = !cnt_q[0];
   assign samp_edge  = tick_i && running && (cfg_q.cpha ? !lead : lead);
   assign shift_edge = tick_i && running &&
                       (cfg_q.cpha ? (lead && (cnt_q != '0)) : !lead);

   assign dly     = (cfg_q.smp == 2'd0) ? 2'd1 : cfg_q.smp;
   assign capture = pipe_q[int'(dly) - 1];
   assign rx_next = capture ? {rxsr_q[WORD_BITS-2:0], miso_i} : rxsr_q;
   assign rx_raw  = cfg_q.wide ? rx_next : {{(WORD_BITS/2){1'b0}}, rx_next[WORD_BITS/2-1:0]};
   assign rx_res  = cfg_q.rx_lsb ? flip_n(rx_raw, cfg_q.wide) : rx_raw;

   assign tx_ord  = cfg_i.tx_lsb ? flip_n(tx_i, cfg_i.wide) : tx_i;
   assign tx_load = cfg_i.wide ? tx_ord : {tx_ord[WORD_BITS/2-1:0], {(WORD_BITS/2){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SH_IDLE;
         cfg_q  <= '0;
         cnt_q  <= '0;
         txsr_q <= '0;
         rxsr_q <= '0;
         rx_q   <= '0;
         sck_q  <= 1'b0;
         pipe_q <= '0;
         dcnt_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pipe_q <= {pipe_q[SMP_TAPS-2:0], samp_edge};
         rxsr_q <= rx_next;
         unique case (st_q)
            SH_IDLE: begin
               sck_q <= cfg_i.cpol;
               if (start_i) begin
                  cfg_q  <= cfg_i;
                  txsr_q <= tx_load;
                  rxsr_q <= '0;
                  cnt_q  <= '0;
                  pipe_q <= '0;
                  st_q   <= SH_RUN;
               end
            end
            SH_RUN: begin
               if (tick_i) begin
                  sck_q <= !sck_q;
                  cnt_q <= cnt_q + 1'b1;
                  if (shift_edge) txsr_q <= {txsr_q[WORD_BITS-2:0], 1'b0};
                  if (cnt_q == last_cnt) begin
                     st_q   <= SH_DRAIN;
                     dcnt_q <= dly;
                  end
               end
            end
            SH_DRAIN: begin
               if (dcnt_q == 2'd1) begin
                  st_q   <= SH_IDLE;
                  done_q <= 1'b1;
                  rx_q   <= rx_res;
               end else begin
                  dcnt_q <= dcnt_q - 1'b1;
               end
            end
            default: st_q <= SH_IDLE;
         endcase
      end
   end

   assign sck_o  = sck_q;
   assign mosi_o = txsr_q[WORD_BITS-1];
   assign busy_o = (st_q != SH_IDLE);
   assign done_o = done_q;
   assign rx_o   = rx_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R8
   AST_SCK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (sck_q == cfg_q.cpol)); // R3
   AST_SCK_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick_i) |=> $stable(sck_q)); // R7
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start_i) |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_CS   = 8,
   parameter int SMP_TAPS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              sck_tick,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);
   localparam int DATA_W = 32;
   localparam int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   xfer_cfg_t            cfg;
   logic                 start, busy, done, cs_en;
   logic [IDX_W-1:0]     cs_idx;
   logic [WORD_BITS-1:0] tx_word, rx_word;

   spi_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .rdata_o(bus_rdata), .busy_i(busy), .done_i(done),
      .rx_i(rx_word), .cfg_o(cfg), .start_o(start), .tx_o(tx_word),
      .cs_en_o(cs_en), .cs_idx_o(cs_idx)
   );

   spi_host_shift #(.SMP_TAPS(SMP_TAPS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg),
      .tx_i(bus_wdata[WORD_BITS-1:0]), .tick_i(sck_tick), .miso_i(spi_miso),
      .sck_o(spi_sck), .mosi_o(spi_mosi), .busy_o(busy), .done_o(done),
      .rx_o(rx_word)
   );

   logic unused_tx;
   assign unused_tx = ^tx_word;

   spi_host_csdec #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_csdec (
      .en_i(cs_en), .idx_i(cs_idx), .cs_n_o(spi_cs_n)
   );

   AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n)); // R2
   AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_en |-> (&spi_cs_n)); // R2
endmodule

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;
   localparam logic [7:0] A_CTRL = 8'h00, A_CONF = 8'h04, A_DOUT = 8'h08,
                          A_DIN = 8'h0C, A_CAUSE = 8'h10, A_TIM = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        sck_tick = 1'b0;
   logic        spi_sck, spi_mosi;
   logic        spi_miso = 1'b0;
   logic [7:0]  spi_cs_n;

   always #2.5 clk = ~clk;

   spi_host_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // tick every 4 cycles
   initial forever begin
      repeat (3) @(negedge clk);
      sck_tick = 1'b1;
      @(negedge clk);
      sck_tick = 1'b0;
   end

   // peripheral model shared settings
   int          s_n = 8;
   bit          s_cpol = 0, s_cpha = 0;
   logic [15:0] s_seq = '0;
   int          s_k = 0, s_lag = 0, s_lagcnt = 0;
   logic        s_pend = 1'b0, s_prev = 1'b0;

   task automatic s_drive(input logic b);
      if (s_lag > 0) begin
         spi_miso = ~b;
         s_pend   = b;
         s_lagcnt = s_lag;
      end else begin
         spi_miso = b;
      end
   endtask

   initial forever begin
      @(negedge clk);
      if (s_lagcnt > 0) begin
         s_lagcnt--;
         if (s_lagcnt == 0) spi_miso = s_pend;
      end
      if (spi_sck !== s_prev) begin
         if (!s_cpha && (spi_sck === s_cpol)) begin
            s_k++;
            if (s_k < s_n) s_drive(s_seq[s_k]);
         end else if (s_cpha && (spi_sck !== s_cpol)) begin
            if (s_k < s_n) s_drive(s_seq[s_k]);
            s_k++;
         end
      end
      s_prev = spi_sck;
   end

   // scoreboard monitor for MOSI
   logic [15:0] exp_q[$];
   logic [15:0] m_bits = '0;
   int          m_nb = 0, m_edges = 0;
   logic        m_prev = 1'b0;

   initial forever begin
      @(negedge clk);
      if (spi_sck !== m_prev) begin
         m_edges++;
         if (s_cpha ? (spi_sck === s_cpol) : (spi_sck !== s_cpol)) begin
            if (m_nb < 16) m_bits[m_nb] = spi_mosi;
            m_nb++;
            if (m_nb == s_n) begin
               if (exp_q.size() == 0) begin
                  chk("R10", "unexpected exchange", {16'h0, m_bits}, 32'h0);
               end else begin
                  logic [15:0] e;
                  e = exp_q.pop_front();
                  chk("R4", "mosi bit sequence", {16'h0, m_bits}, {16'h0, e});
               end
               m_nb   = 0;
               m_bits = '0;
            end
         end
      end
      m_prev = spi_sck;
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   function automatic logic [15:0] rev_n(input logic [15:0] v, input int n);
      logic [15:0] r = '0;
      for (int i = 0; i < n; i++) r[n-1-i] = v[i];
      return r;
   endfunction

   task automatic run_xfer(input bit cpol, input bit cpha, input bit txl,
                           input bit rxl, input bit wide, input logic [1:0] smp,
                           input int lag, input logic [15:0] tx,
                           input logic [15:0] seq, input bit poke, input string tag);
      int          n;
      logic [15:0] mask, eff, exp_rx, exp_mosi;
      logic [31:0] v;
      bit          got;
      n    = wide ? 16 : 8;
      mask = wide ? 16'hFFFF : 16'h00FF;
      wr(A_CONF, (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12) |
                 (32'(txl) << 13) | (32'(rxl) << 14));
      wr(A_TIM, 32'(smp) << 6);
      repeat (3) @(negedge clk);
      chk("R3", "sck idle level", {31'h0, spi_sck}, {31'h0, cpol});
      s_cpol = cpol; s_cpha = cpha; s_n = n; s_seq = seq; s_lag = lag;
      s_k = 0; s_lagcnt = 0; spi_miso = seq[0];
      m_edges = 0; m_nb = 0; m_bits = '0;
      exp_mosi = '0;
      for (int i = 0; i < n; i++) exp_mosi[i] = txl ? tx[i] : tx[n-1-i];
      exp_q.push_back(exp_mosi);
      wr(A_DOUT, {16'h0, tx});
      if (poke) begin
         repeat (20) @(negedge clk);
         wr(A_DOUT, {16'h0, ~tx});
      end
      got = 0;
      v = '0;
      for (int i = 0; i < 3000 && !got; i++) begin
         rd(A_CAUSE, v);
         if (v != 0) got = 1;
      end
      chk("R8", "cause after completion", v, 32'h1);
      eff = seq;
      if (lag > 0 && smp < 2) eff = seq ^ (mask & 16'hFFFE);
      exp_rx = rxl ? (eff & mask) : rev_n(eff, n);
      rd(A_DIN, v);
      chk(tag, "received word", v, {16'h0, exp_rx});
      chk("R3", "edge count", 32'(m_edges), 32'(2*n));
      chk("R3", "sck back at idle", {31'h0, spi_sck}, {31'h0, cpol});
      chk("R4", "scoreboard drained", 32'(exp_q.size()), 32'h0);
      if (poke) begin
         rd(A_DOUT, v);
         chk("R10", "data-out readback after ignored write", v, {16'h0, tx & 16'hFFFF});
      end
      wr(A_CAUSE, 32'h1);
      rd(A_CAUSE, v);
      chk("R8", "cause kept by write of 1", v, 32'h1);
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, v);
      chk("R8", "cause cleared by write of 0", v, 32'h0);
      if (poke) begin
         repeat (150) @(negedge clk);
         rd(A_CAUSE, v);
         chk("R10", "no second exchange (cause)", v, 32'h0);
         chk("R10", "no second exchange (edges)", 32'(m_edges), 32'(2*n));
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #750000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk("R1", "cs lines after reset", {24'h0, spi_cs_n}, 32'h0000_00FF);
      rd(A_CTRL, v);  chk("R1", "control reset", v, 32'h0);
      rd(A_CONF, v);  chk("R1", "config reset", v, 32'h0);
      rd(A_TIM, v);   chk("R1", "timing reset", v, 32'h40);
      rd(A_CAUSE, v); chk("R1", "cause reset", v, 32'h0);
      rd(A_DIN, v);   chk("R1", "data-in reset", v, 32'h0);
      rd(8'h14, v);   chk("R11", "unmapped read", v, 32'h0);

      // R2 select decode
      for (int k = 0; k < 8; k++) begin
         wr(A_CTRL, (32'(k) << 2) | 32'h1);
         @(negedge clk);
         chk("R2", "selected line low", {24'h0, spi_cs_n}, {24'h0, ~(8'h01 << k)});
         wr(A_CTRL, 32'(k) << 2);
         @(negedge clk);
         chk("R2", "select released", {24'h0, spi_cs_n}, 32'h0000_00FF);
      end

      // R11 readback masks
      wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v);
      chk("R11", "control readback", v, 32'h1D);
      wr(A_CONF, 32'hFFFF_FFFF); rd(A_CONF, v);
      chk("R11", "config readback", v, 32'h7820);
      wr(A_TIM, 32'hFFFF_FFFF); rd(A_TIM, v);
      chk("R11", "timing readback", v, 32'hC0);
      wr(A_CTRL, 32'h9);

      // R3 all four modes, 8-bit MSB-first
      run_xfer(0, 0, 0, 0, 0, 2'd1, 0, 16'h00A5, 16'h00C3, 0, "R3 mode0");
      run_xfer(0, 1, 0, 0, 0, 2'd1, 0, 16'h003C, 16'h0096, 0, "R3 mode1");
      run_xfer(1, 0, 0, 0, 0, 2'd1, 0, 16'h0081, 16'h005A, 0, "R3 mode2");
      run_xfer(1, 1, 0, 0, 0, 2'd1, 0, 16'h00E7, 16'h0011, 0, "R3 mode3");
      // R4/R5/R6 bit order and width
      run_xfer(0, 0, 1, 0, 0, 2'd1, 0, 16'h0031, 16'h00F0, 0, "R4 tx lsb-first");
      run_xfer(1, 1, 0, 1, 0, 2'd1, 0, 16'h00D2, 16'h0037, 0, "R5 rx lsb-first");
      run_xfer(0, 1, 1, 1, 1, 2'd1, 0, 16'hBEEF, 16'h1234, 0, "R6 16-bit both lsb");
      run_xfer(1, 0, 0, 0, 1, 2'd1, 0, 16'h8001, 16'hA55A, 0, "R6 16-bit msb");
      run_xfer(0, 0, 0, 0, 0, 2'd1, 0, 16'h00FF, 16'h0001, 0, "R7 single-one word");
      // R9 sample delay against a slow peripheral
      run_xfer(0, 0, 0, 0, 0, 2'd1, 5, 16'h0055, 16'h00B4, 0, "R9 delay1 slow miso");
      run_xfer(0, 0, 0, 0, 0, 2'd2, 5, 16'h0055, 16'h00B4, 0, "R9 delay2 slow miso");
      run_xfer(0, 0, 0, 1, 1, 2'd0, 5, 16'h1357, 16'h6E29, 0, "R9 delay0 as 1");
      run_xfer(0, 0, 0, 0, 1, 2'd3, 5, 16'h2468, 16'h6E29, 0, "R9 delay3 slow miso");
      // R10 write during exchange
      run_xfer(0, 1, 0, 0, 1, 2'd1, 0, 16'h5AA5, 16'hC001, 1, "R10 busy write");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule